// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block sits on a two-wire serial bus as a slave and fronts a byte-wide memory array. It oversamples SCL and SDA with the system clock and finds START and STOP conditions. It answers one of eight bus addresses, picked by three strap inputs. It exposes the array through write and read transfers that carry a two-byte word address. The array is an inferred register array inside the block. Its depth is `2**ADDR_W` bytes, so `ADDR_W = 14` gives a 16 KiB part and the default keeps elaboration small.

A write transfer collects up to one page of data bytes in a staging buffer. Nothing reaches the array until the STOP that closes the transfer. That STOP starts a self-timed programming window of `WRITE_CYCLES` system clocks. The staged bytes are copied into the array during the window, and the slave ignores its own address for as long as the window lasts. A write-protect input, sampled at that STOP, suppresses the copy. Read transfers stream bytes out MSB first for as long as the master acknowledges.

The SDA output is an open-drain enable: when it is 1 the pad pulls the line low, and when it is 0 the line is released.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Before the first START, and after any STOP, the slave never drives SDA. Bytes clocked without a preceding START are not acknowledged.
- R2: The first byte after START is the address byte, sent MSB first. Bits 7..4 must be 1010, bits 3..1 must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a match the slave pulls SDA low for the ninth SCL pulse. On a mismatch it releases SDA and ignores the bus until the next START or STOP.
- R3: In a write transfer the address byte is followed by the high word-address byte and then the low one. Bits of the high byte above `ADDR_W-8` are ignored. The slave acknowledges every byte of the transfer.
- R4: Data bytes are staged and reach the array only after the closing STOP. Within one transfer the low 6 address bits advance after each data byte and wrap inside the 64-byte page, so a later byte at the same offset replaces an earlier one. Locations outside the page are untouched.
- R5: A STOP that ends a write transfer carrying at least one data byte starts a busy window of `WRITE_CYCLES` clocks. During that window the slave does not acknowledge its own address. Once the window ends it acknowledges again.
- R6: If `wp_i` is 1 at the STOP that starts the busy window, the array keeps its previous contents.
- R7: In a read the slave puts each bit on SDA MSB first. It changes its SDA drive only while SCL is low, and it releases SDA for the ninth pulse.
- R8: A read starts at the current address pointer, which may have just been set by a write transfer followed by a repeated START. Each master acknowledge fetches the next byte, and the pointer rolls over from the last location to 0.
- R9: After the master answers a read byte with NACK, the slave releases SDA and sends nothing more until a START or STOP.
- R10: A write transfer that ends with STOP before any data byte only loads the address pointer. It starts no busy window.
- R11: A START in the middle of a write transfer discards any data staged so far, and nothing from that transfer is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad (wired-AND level) |
| strap_i | input | 3 | Board-strapped device address bits |
| wp_i | input | 1 | Write protect, 1 blocks array updates |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |

## Verification
The page-wrap and busy-window behaviour can only be reached through long bus transfers. To cover the wrap, the stimulus starts a 66-byte page write two bytes before the end of a page. It then reads the page back with a sequential read and also checks a neighbouring location written earlier. The lockout is probed by sending the slave's own address right after a committing STOP, while the window is still open, and again after the window has run out. Aborted and address-only writes are told apart from real commits by whether the very next address byte is acknowledged.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int          ADDR_W       = 11,
  parameter int          PAGE_W       = 6,
  parameter int          WRITE_CYCLES = 1000,
  parameter logic [3:0]  DEV_PREFIX   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam int TW    = $clog2(WRITE_CYCLES) + 1;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD, S_WAIT} st_t;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  logic sda_h, scl_rise, scl_fall, start_c, stop_c;
  assign sda_h    = sda_p[1];
  assign scl_rise =  scl_p[1] & ~scl_p[2];
  assign scl_fall = ~scl_p[1] &  scl_p[2];
  assign start_c  = scl_p[1] & scl_p[2] &  sda_p[2] & ~sda_p[1];
  assign stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] &  sda_p[1];

  st_t                     st;
  logic [3:0]              bitcnt;
  logic                    ackslot, rw, mack, oe, have_data, busy, wp_l;
  logic [7:0]              sh;
  logic [ADDR_W-1:0]       ptr;
  logic [PAGE-1:0]         pval;
  logic [TW-1:0]           tmr;
  logic [ADDR_W-PAGE_W-1:0] wpage;

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE];

  logic [7:0]        rd_byte;
  logic [PAGE_W-1:0] cidx;
  logic              cm_we, store_data, byte_end;
  assign rd_byte    = mem[ptr];
  assign cidx       = tmr[PAGE_W-1:0];
  assign cm_we      = busy & ~wp_l & (32'(tmr) < PAGE) & pval[cidx];
  assign byte_end   = scl_fall & ~ackslot & (bitcnt == 4'd8);
  assign store_data = byte_end & (st == S_WR) & ~start_c & ~stop_c;
  assign sda_oe_o   = oe;

  always_ff @(posedge clk)
    if (cm_we) mem[{wpage, cidx}] <= pbuf[cidx];

  always_ff @(posedge clk)
    if (store_data) pbuf[ptr[PAGE_W-1:0]] <= sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; ackslot <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      oe <= 1'b0; have_data <= 1'b0; busy <= 1'b0; wp_l <= 1'b0; sh <= '0;
      ptr <= '0; pval <= '0; tmr <= '0; wpage <= '0;
    end else begin
      if (busy) begin
        if (32'(tmr) == WRITE_CYCLES - 1) begin
          busy <= 1'b0;
          pval <= '0;
        end else tmr <= tmr + 1'b1;
      end

      if (start_c) begin
        st <= S_DEV; bitcnt <= '0; ackslot <= 1'b0; oe <= 1'b0; have_data <= 1'b0;
        if (!busy) pval <= '0;
      end else if (stop_c) begin
        st <= S_IDLE; bitcnt <= '0; ackslot <= 1'b0; oe <= 1'b0; have_data <= 1'b0;
        if (have_data && !busy) begin
          busy  <= 1'b1;
          tmr   <= '0;
          wpage <= ptr[ADDR_W-1:PAGE_W];
          wp_l  <= wp_i;
        end
      end else if (st != S_IDLE && st != S_WAIT) begin
        if (scl_rise) begin
          if (ackslot) mack <= ~sda_h;
          else begin
            bitcnt <= bitcnt + 1'b1;
            if (st != S_RD) sh <= {sh[6:0], sda_h};
          end
        end else if (byte_end) begin
          ackslot <= 1'b1;
          case (st)
            S_DEV: if (sh[7:1] == {DEV_PREFIX, strap_i} && !busy) begin
                     oe <= 1'b1;
                     rw <= sh[0];
                   end else st <= S_WAIT;
            S_AHI: begin oe <= 1'b1; ptr[ADDR_W-1:8] <= sh[HI_W-1:0]; end
            S_ALO: begin oe <= 1'b1; ptr[7:0] <= sh; end
            S_WR: begin
              oe <= 1'b1;
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              pval[ptr[PAGE_W-1:0]] <= 1'b1;
              have_data <= 1'b1;
            end
            default: oe <= 1'b0;
          endcase
        end else if (scl_fall && ackslot) begin
          ackslot <= 1'b0; bitcnt <= '0; oe <= 1'b0;
          case (st)
            S_DEV: if (rw) begin
                     st <= S_RD; sh <= rd_byte; ptr <= ptr + 1'b1; oe <= ~rd_byte[7];
                   end else st <= S_AHI;
            S_AHI: st <= S_ALO;
            S_ALO: st <= S_WR;
            S_RD: if (mack) begin
                    sh <= rd_byte; ptr <= ptr + 1'b1; oe <= ~rd_byte[7];
                  end else st <= S_WAIT;
            default: st <= st;
          endcase
        end else if (scl_fall && st == S_RD && bitcnt != 4'd0) begin
          sh <= {sh[6:0], 1'b0};
          oe <= ~sh[6];
        end
      end
    end

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !oe);
  assert_quiet_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !oe);
  assert_busy_from_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_c));
  assert_stage_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pval));
  assert_stage_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pval == '0));
  assert_drive_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_p[1]);
  assert_bitcnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);

endmodule

// File: tb/i2c_eeprom_slave_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;
  localparam int AW = 11;
  localparam int WC = 300;
  localparam int Q  = 5;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(AW), .PAGE_W(6), .WRITE_CYCLES(WC), .DEV_PREFIX(4'b1010)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
    .wp_i(wp), .sda_oe_o(sda_oe));

  int tests = 0, fails = 0, viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe != prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_scl = 1'b0; wq(1); m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(2);
    m_sda = 1'b0; wq(2); m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; wq(1); m_sda = 1'b0; wq(1); m_scl = 1'b1; wq(2);
    m_sda = 1'b1; wq(2);
  endtask

  task automatic put_bit(input logic b);
    m_scl = 1'b0; wq(1); m_sda = b; wq(1); m_scl = 1'b1; wq(2); m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wq(1); m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(1); b = sda_bus; wq(1); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!give_ack);
  endtask

  task automatic mem_write(input logic [AW-1:0] a, input int n, input logic [7:0] d0,
                           output bit all_ack);
    bit k;
    bus_start();
    send_byte(8'hAA, k); all_ack = k;
    send_byte({5'b11111, a[10:8]}, k); all_ack &= k;
    send_byte(a[7:0], k); all_ack &= k;
    for (int i = 0; i < n; i++) begin
      send_byte(d0 + 8'(i), k); all_ack &= k;
    end
    bus_stop();
  endtask

  task automatic rd_setup(input logic [AW-1:0] a, output bit all_ack);
    bit k;
    bus_start();
    send_byte(8'hAA, k); all_ack = k;
    send_byte({5'b00000, a[10:8]}, k); all_ack &= k;
    send_byte(a[7:0], k); all_ack &= k;
    bus_start();
    send_byte(8'hAB, k); all_ack &= k;
  endtask

  task automatic read_one(input logic [AW-1:0] a, output logic [7:0] d);
    bit k;
    rd_setup(a, k);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic wait_prog();
    repeat (WC + 20) @(negedge clk);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic logic [7:0] page_exp(input int o);
    if (o == 62) return 8'h80;
    if (o == 63) return 8'h81;
    return 8'(8'h40 + o + 2);
  endfunction

  // {wp, addr[10:0], data, expected readback}
  localparam logic [27:0] TBL [8] = '{
    {1'b0, 11'h000, 8'hC3, 8'hC3},
    {1'b0, 11'h010, 8'hA5, 8'hA5},
    {1'b0, 11'h7FF, 8'h3C, 8'h3C},
    {1'b1, 11'h010, 8'hFF, 8'hA5},
    {1'b0, 11'h123, 8'h81, 8'h81},
    {1'b1, 11'h123, 8'h00, 8'h81},
    {1'b0, 11'h0C0, 8'h77, 8'h77},
    {1'b0, 11'h400, 8'h5A, 8'h5A}
  };

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      report();
    end
  end

  initial begin
    bit k;
    logic [7:0] d;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);

    // R1: address byte without START is ignored
    send_byte(8'hAA, k);
    check(!k, "R1 no START no ack", k, 0);
    bus_stop();

    // R2: strap and prefix mismatch
    bus_start(); send_byte(8'hA6, k); bus_stop();
    check(!k, "R2 strap mismatch", k, 0);
    bus_start(); send_byte(8'hBA, k); bus_stop();
    check(!k, "R2 prefix mismatch", k, 0);

    for (int i = 0; i < 8; i++) begin
      wp = TBL[i][27];
      mem_write(TBL[i][26:16], 1, TBL[i][15:8], k);
      check(k, "R3 write acks", k, 1);
      wait_prog();
      wp = 1'b0;
      read_one(TBL[i][26:16], d);
      check(d == TBL[i][7:0], TBL[i][27] ? "R6 protected" : "R4 byte write", d, TBL[i][7:0]);
    end

    // R5: lockout during busy window
    mem_write(11'h200, 1, 8'h11, k);
    bus_start(); send_byte(8'hAA, k); bus_stop();
    check(!k, "R5 busy nack", k, 0);
    wait_prog();
    bus_start(); send_byte(8'hAA, k); bus_stop();
    check(k, "R5 ack after window", k, 1);
    read_one(11'h200, d);
    check(d == 8'h11, "R5 committed", d, 8'h11);

    // R10: address-only write
    bus_start(); send_byte(8'hAA, k); send_byte(8'h01, k); send_byte(8'h23, k); bus_stop();
    bus_start(); send_byte(8'hAB, k);
    check(k, "R10 no busy", k, 1);
    recv_byte(1'b0, d); bus_stop();
    check(d == 8'h81, "R10 pointer loaded", d, 8'h81);

    // R11: repeated START aborts staged data
    bus_start(); send_byte(8'hAA, k); send_byte(8'h01, k); send_byte(8'h23, k);
    send_byte(8'hEE, k);
    bus_start(); send_byte(8'hAA, k); bus_stop();
    bus_start(); send_byte(8'hAA, k); bus_stop();
    check(k, "R11 no busy after abort", k, 1);
    read_one(11'h123, d);
    check(d == 8'h81, "R11 data discarded", d, 8'h81);

    // R4: 66-byte page write starting at offset 62, wraps in page
    mem_write(11'h0BE, 66, 8'h40, k);
    check(k, "R4 page acks", k, 1);
    wait_prog();
    rd_setup(11'h080, k);
    for (int o = 0; o < 64; o++) begin
      recv_byte(o < 63, d);
      check(d == page_exp(o), "R4 page wrap", d, page_exp(o));
    end
    bus_stop();
    read_one(11'h0C0, d);
    check(d == 8'h77, "R4 next page untouched", d, 8'h77);

    // R8: rollover from last location to 0
    rd_setup(11'h7FF, k);
    recv_byte(1'b1, d);
    check(d == 8'h3C, "R8 last location", d, 8'h3C);
    recv_byte(1'b0, d);
    check(d == 8'hC3, "R8 rollover", d, 8'hC3);
    bus_stop();

    // R9: after NACK the slave stays silent
    rd_setup(11'h010, k);
    recv_byte(1'b0, d);
    check(d == 8'hA5, "R9 read byte", d, 8'hA5);
    recv_byte(1'b0, d);
    check(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    bus_stop();

    check(viol == 0, "R7 drive change while SCL high", viol, 0);

    done = 1'b1;
    report();
  end
endmodule